// File: doc/BRIEF.md
# Non-Restoring Division Step

This block carries out one bit of a non-restoring binary division. It takes a divisor, a partial remainder and three status bits: the running quotient-sign bit Q, the divisor-sign bit M and the carry-in bit T. It returns the next partial remainder together with the updated Q and T. The arithmetic is one combinational add-or-subtract. The remainder, Q and T are captured in registers on the clock edge at which `step_valid` is high.

A sequencer outside this block sets up the initial Q, M and T and repeats the step. For an unsigned 32-by-32 division, Q, M and T start at zero and the remainder starts at zero. Before each step the dividend word is rotated left through T, and the remainder, Q and T from the registered outputs are fed back. After 32 steps and one last rotate, the dividend word holds the quotient.

Top module: `divstep_unit`

## Requirements
- R1: The intermediate Q is bit W-1 of `rem_in`, taken before the shift.
- R2: The shifted operand is `rem_in` moved left one place, with `t_in` placed in bit 0.
- R3: When `q_in` equals `m_in`, the divisor is subtracted from the shifted operand. Otherwise it is added. The W-bit result appears on `rem_out`.
- R4: When the divisor is subtracted, the flag is the borrow out of bit W-1 (result greater than the shifted operand). The new Q is that flag when the intermediate Q is 0, and its inverse when the intermediate Q is 1.
- R5: When the divisor is added, the flag is the carry out of bit W-1 (result less than the shifted operand). For `q_in`=1, `m_in`=0 the new Q is the flag when the intermediate Q is 0 and its inverse when it is 1. For `q_in`=0, `m_in`=1 the new Q is the inverted flag when the intermediate Q is 0 and the flag itself when it is 1.
- R6: `t_out` is 1 exactly when the new Q equals `m_in`.
- R7: `rem_out`, `q_out` and `t_out` update on the same rising edge, one cycle after `step_valid` is sampled high. While `step_valid` is low they hold their values, whatever the other inputs do.
- R8: While `rst_n` is low, `rem_out`, `q_out` and `t_out` are all 0.
- R9: Start with Q=M=T=0 and a remainder of 0. Repeat 32 times: rotate the dividend left through T, then run one step with the outputs fed back. After a final rotate through T, the dividend word equals the unsigned quotient of dividend by divisor, for any non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Perform and capture one step this cycle |
| divisor | input | W | Divisor operand |
| rem_in | input | W | Partial remainder before the step |
| q_in | input | 1 | Q status before the step |
| m_in | input | 1 | M status (divisor sign) |
| t_in | input | 1 | T status, shifted into bit 0 |
| rem_out | output | W | Registered partial remainder after the step |
| q_out | output | 1 | Registered new Q |
| t_out | output | 1 | Registered new T |

## Verification
Every result of a step is due on the first rising edge at which `step_valid` is sampled high. The bench drives inputs on the falling edge and reads the outputs 1 ns after the following rising edge. For hold checks, it drives changed inputs with `step_valid` low across one full edge and expects the earlier values. The 32-step chains use the same timing: each step's registered outputs are fed back at the next falling edge. The quotient is compared only after the final rotate.

// File: rtl/divstep_unit.sv
module divstep_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_valid,
  input  logic [W-1:0] divisor,
  input  logic [W-1:0] rem_in,
  input  logic         q_in,
  input  logic         m_in,
  input  logic         t_in,
  output logic [W-1:0] rem_out,
  output logic         q_out,
  output logic         t_out
);

  logic         q_mid;
  logic         do_sub;
  logic [W-1:0] shifted;
  logic [W:0]   wide;
  logic         flag;
  logic         q_next;

  assign q_mid   = rem_in[W-1];
  assign shifted = {rem_in[W-2:0], t_in};
  assign do_sub  = (q_in == m_in);
  assign wide    = do_sub ? ({1'b0, shifted} - {1'b0, divisor})
                          : ({1'b0, shifted} + {1'b0, divisor});
  assign flag    = wide[W];
  assign q_next  = q_mid ^ flag ^ (~q_in & m_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_out <= '0;
      q_out   <= 1'b0;
      t_out   <= 1'b0;
    end else if (step_valid) begin
      rem_out <= wide[W-1:0];
      q_out   <= q_next;
      t_out   <= (q_next == m_in);
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> ($stable(rem_out) && $stable(q_out) && $stable(t_out)));

  p_t_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> (t_out == (q_out == $past(m_in))));

  p_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> (rem_out[0] == ($past(t_in) ^ $past(divisor[0]))));

  p_sub_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && q_in == m_in) |=>
      (rem_out + $past(divisor) == {$past(rem_in[W-2:0]), $past(t_in)}));

  p_add_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && q_in != m_in) |=>
      (rem_out - $past(divisor) == {$past(rem_in[W-2:0]), $past(t_in)}));

  always_ff @(posedge clk) begin
    if (!rst_n) p_reset_r8: assert (rem_out == '0 && !q_out && !t_out);
  end

endmodule

// File: tb/test_divstep_unit.sv
`timescale 1ns/1ps
module test_divstep_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_valid = 1'b0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] rem_in = '0;
  logic         q_in = 1'b0, m_in = 1'b0, t_in = 1'b0;
  logic [W-1:0] rem_out;
  logic         q_out, t_out;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  divstep_unit #(.W(W)) i_divstep_unit (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .divisor(divisor),
    .rem_in(rem_in), .q_in(q_in), .m_in(m_in), .t_in(t_in),
    .rem_out(rem_out), .q_out(q_out), .t_out(t_out)
  );

  typedef struct packed { logic [W-1:0] r; logic q; logic t; } res_t;

  function automatic res_t ref_step(logic [W-1:0] d, logic [W-1:0] r,
                                    logic oq, logic m, logic t);
    res_t o;
    logic qi, fl;
    logic [W-1:0] sh;
    qi = r[W-1];
    sh = (r << 1) | W'(t);
    if (oq == m) begin
      o.r = sh - d;
      fl = (o.r > sh);
    end else begin
      o.r = sh + d;
      fl = (o.r < sh);
    end
    case ({oq, m})
      2'b00, 2'b11, 2'b10: o.q = qi ? !fl : fl;
      default:             o.q = qi ? fl : !fl;
    endcase
    o.t = (o.q == m);
    return o;
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [W-1:0] d, logic [W-1:0] r, logic oq, logic m, logic t);
    @(negedge clk);
    divisor = d; rem_in = r; q_in = oq; m_in = m; t_in = t; step_valid = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic one_vec(logic [W-1:0] d, logic [W-1:0] r, logic oq, logic m, logic t);
    res_t e;
    e = ref_step(d, r, oq, m, t);
    step(d, r, oq, m, t);
    check(rem_out == e.r, "R2/R3 remainder", rem_out, e.r);
    if (oq == m) check(q_out == e.q, "R1/R4 q", W'(q_out), W'(e.q));
    else         check(q_out == e.q, "R1/R5 q", W'(q_out), W'(e.q));
    check(t_out == e.t, "R6 t", W'(t_out), W'(e.t));
  endtask

  task automatic hold_check();
    logic [W-1:0] r0;
    logic q0, t0;
    r0 = rem_out; q0 = q_out; t0 = t_out;
    @(negedge clk);
    divisor = ~divisor; rem_in = ~rem_in; q_in = ~q_in; m_in = ~m_in; t_in = ~t_in;
    step_valid = 1'b0;
    @(posedge clk); #1;
    check(rem_out == r0 && q_out == q0 && t_out == t0, "R7 hold", rem_out, r0);
  endtask

  task automatic divide(logic [W-1:0] a, logic [W-1:0] d);
    logic [W-1:0] lo, hi, expq;
    logic q, t, nt;
    lo = a; hi = '0; q = 1'b0; t = 1'b0;
    for (int i = 0; i < W; i++) begin
      nt = lo[W-1];
      lo = {lo[W-2:0], t};
      t = nt;
      step(d, hi, q, 1'b0, t);
      hi = rem_out; q = q_out; t = t_out;
    end
    lo = {lo[W-2:0], t};
    expq = a / d;
    check(lo == expq, "R9 quotient", lo, expq);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #12;
    check(rem_out == '0 && !q_out && !t_out, "R8 reset", rem_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    one_vec(32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
    one_vec(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    one_vec(32'h0000_0001, 32'h8000_0000, 1'b1, 1'b1, 1'b0);
    one_vec(32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
    one_vec(32'h8000_0000, 32'hC000_0000, 1'b1, 1'b0, 1'b0);
    one_vec(32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1, 1'b0);
    hold_check();

    for (int i = 0; i < 1500; i++) begin
      one_vec($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
      if (i % 100 == 0) hold_check();
    end

    divide(32'd0, 32'd7);
    divide(32'hFFFF_FFFF, 32'd1);
    divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    divide(32'd100, 32'd7);
    divide(32'h8000_0000, 32'h8000_0001);
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] d;
      d = $urandom;
      if (i % 3 == 0) d = d >> ($urandom % 31);
      if (d == 0) d = 1;
      divide($urandom, d);
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rem_out == '0 && !q_out && !t_out, "R8 reset again", rem_out, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule